// File: doc/BRIEF.md
# Programmable Field Sequence Selector

This block chooses which stored vertical-timing field an image sensor timing generator plays during each frame period. Software loads a sequence of up to seven 5-bit field indices and a sequence length. On every falling edge of the vertical-drive (VD) signal the block steps to the next entry of that list, and it wraps back to the first entry after the last one in use. The selected index and a one-cycle change strobe go to the timing memory, which sits outside this block.

Three registers are written through a plain address/data/strobe port. The length register is at 0x2A. The word at 0x2B carries the first five list entries and the word at 0x2C carries the last two. A write to 0x2C is the only write that sends the sequence back to its first entry. Writes to the other two registers replace contents without moving the position. The `vd_sync_mode` input selects the update policy. When it is low, a written value becomes active on the next clock. When it is high, written values wait in a staging copy, and an update state machine moves them into the active set on the second VD falling edge after the most recent write. The states are UPD_IDLE, UPD_ARMED and UPD_WAIT2:
- A write in any state goes to UPD_ARMED.
- A VD fall in UPD_ARMED with no write goes to UPD_WAIT2.
- A VD fall in UPD_WAIT2 with no write commits the staging copy and returns to UPD_IDLE.
- A VD fall in UPD_WAIT2 that coincides with a write commits the staging copy and goes to UPD_ARMED.

Top module: `field_seq_sel`

## Requirements
- R1: The length is held in bits [2:0] of the word at 0x2A. A length of 0 acts as 1, so the sequence then stays on entry 0.
- R2: Entry k (k = 0..4) is in bits [5k+4:5k] of the word at 0x2B. Entry 5 is in bits [4:0] and entry 6 is in bits [9:5] of the word at 0x2C.
- R3: When the position restarts, the position becomes 0, `field_idx` takes the content of entry 0 and `field_stb` pulses.
- R4: Each VD falling edge moves the position to the next entry, and `field_idx` takes that entry's content.
- R5: After the entry numbered length minus one, the next VD falling edge returns the position to entry 0.
- R6: Only an activated write to 0x2C restarts the position. A write to 0x2A or 0x2B leaves `field_idx` unchanged until the next VD falling edge.
- R7: With `vd_sync_mode` low, written values are active from the next clock, and the next step uses them.
- R8: With `vd_sync_mode` high, written values are staged and become active on the second VD falling edge after the write. Until then, steps use the old values. If 0x2C was among the staged writes, that edge restarts the position.
- R9: `field_stb` is high for exactly one cycle each time `field_idx` is loaded, and `field_idx` changes at no other time. A commit that restarts the position produces one load, not two.
- R10: After reset, `field_idx` is 0, `field_stb` is 0, the length is 0 and all entries are 0.
- R11: After `vd_in` falls, `field_idx` and `field_stb` change at the third rising clock edge that samples `vd_in` low.
- R12: With `vd_sync_mode` high, a further write while a commit is pending restarts the two-edge wait from that write.
- R13: Writes to any address other than 0x2A, 0x2B and 0x2C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 25 | Register write data |
| vd_in | input | 1 | Vertical drive, asynchronous to clk |
| vd_sync_mode | input | 1 | 1 = stage writes until the second VD fall, 0 = apply at once |
| field_idx | output | 5 | Currently selected field index |
| field_stb | output | 1 | One-cycle pulse when field_idx is loaded |

## Verification
A VD step is due at the third rising clock edge after `vd_in` goes low: two edges of synchronizer and one edge of index register. The bench checks that step at exactly that edge once, and otherwise samples several cycles after each VD edge. A restart after an immediate write to 0x2C is due at the second edge after the write strobe is sampled, so the bench waits two falling clock edges before it reads. A restarting commit in VD-synchronous mode lands one edge after the normal step point, and the bench counts strobes over the whole VD pulse to confirm that exactly one load occurred. All sampling happens on the falling clock edge, away from the edges where the design changes.

// File: rtl/fss_pkg.sv
package fss_pkg;

    // Update policy state machine for VD-synchronous register staging
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,   // nothing staged
        UPD_ARMED = 2'd1,   // staged, waiting for first VD fall
        UPD_WAIT2 = 2'd2    // first VD fall seen, commit on the next one
    } upd_state_e;

endpackage

// File: rtl/fss_vd_sync.sv
module fss_vd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vd_in,
    output logic vd_fall
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // VD idles high, so the chain resets high to avoid a false fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], vd_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign vd_fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/fss_regbank.sv
module fss_regbank
    import fss_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                SLOT_W    = 5,
    parameter int                NUM_SLOTS = 7,
    parameter int                SLOTS_LO  = 5,
    parameter int                CNT_W     = 3,
    parameter logic [ADDR_W-1:0] ADDR_CNT  = 'h2A,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 'h2B,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 'h2C
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [SLOTS_LO*SLOT_W-1:0]    wr_data,
    input  logic                          sync_mode,
    input  logic                          vd_fall,
    output logic [CNT_W-1:0]              act_cnt,
    output logic [NUM_SLOTS*SLOT_W-1:0]   act_slots,
    output logic                          restart,
    output logic                          commit_restart,
    output upd_state_e                    upd_state
);

    localparam int LO_W  = SLOTS_LO * SLOT_W;
    localparam int HI_W  = (NUM_SLOTS - SLOTS_LO) * SLOT_W;
    localparam int TOT_W = NUM_SLOTS * SLOT_W;

    upd_state_e           state_q, state_d;
    logic [CNT_W-1:0]     stg_cnt_q, act_cnt_q;
    logic [TOT_W-1:0]     stg_slots_q, act_slots_q;
    logic                 stg_rst_q;
    logic                 restart_q;

    logic hit_cnt, hit_lo, hit_hi, sync_wr, commit;

    assign hit_cnt = wr_en && (wr_addr == ADDR_CNT);
    assign hit_lo  = wr_en && (wr_addr == ADDR_LO);
    assign hit_hi  = wr_en && (wr_addr == ADDR_HI);
    assign sync_wr = (hit_cnt || hit_lo || hit_hi) && sync_mode;
    assign commit  = (state_q == UPD_WAIT2) && vd_fall;
    assign commit_restart = commit && stg_rst_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: any staged write re-arms the two-edge wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE: begin
                if (sync_wr) state_d = UPD_ARMED;
            end
            UPD_ARMED: begin
                if (sync_wr)      state_d = UPD_ARMED;
                else if (vd_fall) state_d = UPD_WAIT2;
            end
            UPD_WAIT2: begin
                if (sync_wr)      state_d = UPD_ARMED;
                else if (vd_fall) state_d = UPD_IDLE;
            end
            default: state_d = UPD_IDLE;
        endcase
    end

    // Staging copy: follows every write so it mirrors the last programmed values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_cnt_q   <= '0;
            stg_slots_q <= '0;
            stg_rst_q   <= 1'b0;
        end else begin
            if (hit_cnt) stg_cnt_q <= wr_data[CNT_W-1:0];
            if (hit_lo)  stg_slots_q[LO_W-1:0] <= wr_data;
            if (hit_hi)  stg_slots_q[TOT_W-1:LO_W] <= wr_data[HI_W-1:0];
            if (hit_hi && sync_mode) stg_rst_q <= 1'b1;
            else if (commit)         stg_rst_q <= 1'b0;
        end
    end

    // Output process: active set and restart pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt_q   <= '0;
            act_slots_q <= '0;
            restart_q   <= 1'b0;
        end else begin
            if (commit) begin
                act_cnt_q   <= stg_cnt_q;
                act_slots_q <= stg_slots_q;
            end
            if (!sync_mode) begin
                if (hit_cnt) act_cnt_q <= wr_data[CNT_W-1:0];
                if (hit_lo)  act_slots_q[LO_W-1:0] <= wr_data;
                if (hit_hi)  act_slots_q[TOT_W-1:LO_W] <= wr_data[HI_W-1:0];
            end
            restart_q <= (hit_hi && !sync_mode) || commit_restart;
        end
    end

    assign act_cnt   = act_cnt_q;
    assign act_slots = act_slots_q;
    assign restart   = restart_q;
    assign upd_state = state_q;

endmodule

// File: rtl/fss_sequencer.sv
module fss_sequencer #(
    parameter int SLOT_W    = 5,
    parameter int NUM_SLOTS = 7,
    parameter int CNT_W     = 3,
    parameter int POS_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            act_cnt,
    input  logic [NUM_SLOTS*SLOT_W-1:0] act_slots,
    input  logic                        adv,
    input  logic                        restart,
    output logic [SLOT_W-1:0]           field_idx,
    output logic                        field_stb,
    output logic [POS_W-1:0]            pos
);

    logic [SLOT_W-1:0] slot_arr [NUM_SLOTS];
    logic [CNT_W-1:0]  cnt_eff;
    logic [POS_W-1:0]  pos_q, nxt_pos;
    logic [SLOT_W-1:0] idx_q;
    logic              stb_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_unpack
        assign slot_arr[k] = act_slots[k*SLOT_W +: SLOT_W];
    end

    // Length 0 behaves as 1; lengths beyond the list are clamped
    always_comb begin
        if (act_cnt == '0)                       cnt_eff = CNT_W'(1);
        else if (act_cnt > CNT_W'(NUM_SLOTS))    cnt_eff = CNT_W'(NUM_SLOTS);
        else                                     cnt_eff = act_cnt;
    end

    always_comb begin
        if (int'(pos_q) + 1 >= int'(cnt_eff)) nxt_pos = '0;
        else                                  nxt_pos = pos_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            idx_q <= '0;
            stb_q <= 1'b0;
        end else if (restart) begin
            pos_q <= '0;
            idx_q <= slot_arr[0];
            stb_q <= 1'b1;
        end else if (adv) begin
            pos_q <= nxt_pos;
            idx_q <= slot_arr[nxt_pos];
            stb_q <= 1'b1;
        end else begin
            stb_q <= 1'b0;
        end
    end

    assign field_idx = idx_q;
    assign field_stb = stb_q;
    assign pos       = pos_q;

endmodule

// File: rtl/field_seq_sel.sv
module field_seq_sel
    import fss_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                SLOT_W    = 5,
    parameter int                NUM_SLOTS = 7,
    parameter int                SLOTS_LO  = 5,
    parameter int                VD_STAGES = 2,
    parameter logic [ADDR_W-1:0] ADDR_CNT  = 'h2A,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 'h2B,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 'h2C
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [SLOTS_LO*SLOT_W-1:0] wr_data,
    input  logic                       vd_in,
    input  logic                       vd_sync_mode,
    output logic [SLOT_W-1:0]          field_idx,
    output logic                       field_stb
);

    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam int POS_W = $clog2(NUM_SLOTS);
    localparam int TOT_W = NUM_SLOTS * SLOT_W;

    logic              vd_fall;
    logic              restart;
    logic              commit_restart;
    logic              seq_adv;
    upd_state_e        upd_state;
    logic [CNT_W-1:0]  act_cnt;
    logic [TOT_W-1:0]  act_slots;
    logic [POS_W-1:0]  seq_pos;

    fss_vd_sync #(
        .STAGES (VD_STAGES)
    ) u_vd_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .vd_in   (vd_in),
        .vd_fall (vd_fall)
    );

    fss_regbank #(
        .ADDR_W    (ADDR_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .SLOTS_LO  (SLOTS_LO),
        .CNT_W     (CNT_W),
        .ADDR_CNT  (ADDR_CNT),
        .ADDR_LO   (ADDR_LO),
        .ADDR_HI   (ADDR_HI)
    ) u_regbank (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .sync_mode      (vd_sync_mode),
        .vd_fall        (vd_fall),
        .act_cnt        (act_cnt),
        .act_slots      (act_slots),
        .restart        (restart),
        .commit_restart (commit_restart),
        .upd_state      (upd_state)
    );

    // A restarting commit replaces the step of that VD edge
    assign seq_adv = vd_fall && !commit_restart;

    fss_sequencer #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W),
        .POS_W     (POS_W)
    ) u_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_cnt   (act_cnt),
        .act_slots (act_slots),
        .adv       (seq_adv),
        .restart   (restart),
        .field_idx (field_idx),
        .field_stb (field_stb),
        .pos       (seq_pos)
    );

endmodule

// File: rtl/fss_checker.sv
module fss_checker
    import fss_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                SLOT_W    = 5,
    parameter int                NUM_SLOTS = 7,
    parameter int                CNT_W     = 3,
    parameter int                POS_W     = 3,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 'h2C
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic                        sync_mode,
    input logic                        vd_fall,
    input upd_state_e                  upd_state,
    input logic                        restart,
    input logic                        adv,
    input logic [CNT_W-1:0]            act_cnt,
    input logic [NUM_SLOTS*SLOT_W-1:0] act_slots,
    input logic [POS_W-1:0]            pos,
    input logic [SLOT_W-1:0]           field_idx,
    input logic                        field_stb
);

    AST_STB_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || adv) |=> field_stb);                                   // R9
    AST_STB_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(restart || adv) |=> !field_stb);                                 // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |-> $stable(field_idx));                                // R9
    AST_RESTART_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pos == '0) && (field_idx == $past(act_slots[SLOT_W-1:0]))); // R3
    AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart) |=> (pos == '0) || (pos == POS_W'($past(pos) + 1'b1))); // R5
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(upd_state == UPD_WAIT2 && vd_fall) && !(wr_en && !sync_mode))
        |=> ($stable(act_cnt) && $stable(act_slots)));                     // R8
    AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ($past(wr_en && wr_addr == ADDR_HI && !sync_mode)
                     || $past(upd_state == UPD_WAIT2 && vd_fall)));        // R6

endmodule

bind field_seq_sel fss_checker #(
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W),
    .POS_W     (POS_W),
    .ADDR_HI   (ADDR_HI)
) u_fss_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .sync_mode (vd_sync_mode),
    .vd_fall   (vd_fall),
    .upd_state (upd_state),
    .restart   (restart),
    .adv       (seq_adv),
    .act_cnt   (act_cnt),
    .act_slots (act_slots),
    .pos       (seq_pos),
    .field_idx (field_idx),
    .field_stb (field_stb)
);

// File: tb/field_seq_sel_tb_top.sv
module field_seq_sel_tb_top;

    localparam int CLK_P = 10;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_CHK = 2'd1;
    localparam logic [1:0] OP_VD  = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [24:0] data;
        logic [4:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{OP_WR,  8'h2A, 25'd3, 5'd0, 4'd1},                               // R1 length 3
        '{OP_WR,  8'h2B, {5'd30,5'd2,5'd17,5'd9,5'd4}, 5'd0, 4'd2},        // R2 entries 0..4
        '{OP_CHK, 8'h00, 25'd0, 5'd0, 4'd6},                               // R6 no restart yet
        '{OP_WR,  8'h2C, {15'd0,5'd12,5'd21}, 5'd0, 4'd2},                 // R2 entries 5,6
        '{OP_CHK, 8'h00, 25'd0, 5'd4, 4'd3},                               // R3 restart to entry 0
        '{OP_VD,  8'h00, 25'd0, 5'd9, 4'd4},                               // R4
        '{OP_VD,  8'h00, 25'd0, 5'd17, 4'd4},                              // R4
        '{OP_VD,  8'h00, 25'd0, 5'd4, 4'd5},                               // R5 wrap at 3
        '{OP_VD,  8'h00, 25'd0, 5'd9, 4'd5},                               // R5
        '{OP_WR,  8'h2A, 25'd7, 5'd0, 4'd7},                               // R7 length 7
        '{OP_CHK, 8'h00, 25'd0, 5'd9, 4'd6},                               // R6 position kept
        '{OP_VD,  8'h00, 25'd0, 5'd17, 4'd7},                              // R7
        '{OP_VD,  8'h00, 25'd0, 5'd2, 4'd4},                               // R4
        '{OP_VD,  8'h00, 25'd0, 5'd30, 4'd4},                              // R4
        '{OP_VD,  8'h00, 25'd0, 5'd21, 4'd2},                              // R2 entry 5
        '{OP_VD,  8'h00, 25'd0, 5'd12, 4'd2},                              // R2 entry 6
        '{OP_VD,  8'h00, 25'd0, 5'd4, 4'd5},                               // R5 wrap at 7
        '{OP_WR,  8'h2A, 25'd0, 5'd0, 4'd1},                               // R1 length 0
        '{OP_CHK, 8'h00, 25'd0, 5'd4, 4'd6},                               // R6
        '{OP_VD,  8'h00, 25'd0, 5'd4, 4'd1},                               // R1 holds entry 0
        '{OP_VD,  8'h00, 25'd0, 5'd4, 4'd1},                               // R1
        '{OP_WR,  8'h2A, 25'd2, 5'd0, 4'd7},                               // R7 length 2
        '{OP_WR,  8'h2B, {5'd30,5'd2,5'd17,5'd7,5'd4}, 5'd0, 4'd7},        // R7 entry 1 = 7
        '{OP_CHK, 8'h00, 25'd0, 5'd4, 4'd6},                               // R6
        '{OP_VD,  8'h00, 25'd0, 5'd7, 4'd7},                               // R7
        '{OP_VD,  8'h00, 25'd0, 5'd4, 4'd5},                               // R5
        '{OP_WR,  8'h2D, 25'h1FFFFFF, 5'd0, 4'd13},                        // R13 foreign address
        '{OP_VD,  8'h00, 25'd0, 5'd7, 4'd13},                              // R13 length still 2
        '{OP_VD,  8'h00, 25'd0, 5'd4, 4'd13}                               // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [24:0] wr_data = '0;
    logic        vd_in = 1'b1;
    logic        vd_sync_mode = 1'b0;
    logic [4:0]  field_idx;
    logic        field_stb;

    int n_chk = 0;
    int n_fail = 0;
    int stb_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) if (field_stb) stb_seen++;

    field_seq_sel dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .vd_in        (vd_in),
        .vd_sync_mode (vd_sync_mode),
        .field_idx    (field_idx),
        .field_stb    (field_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [24:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vd_pulse();
        @(negedge clk); vd_in = 1'b0;
        repeat (5) @(negedge clk);
        vd_in = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic vd_check(input string req, input int exp);
        int s0;
        s0 = stb_seen;
        vd_pulse();
        check(req, int'(field_idx), exp);
        check({req, " strobe count"}, stb_seen - s0, 1);
    endtask

    task automatic wait_chk(input string req, input int exp);
        repeat (2) @(negedge clk);
        check(req, int'(field_idx), exp);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset index", int'(field_idx), 0);
        check("R10 reset strobe", int'(field_stb), 0);
        repeat (4) @(negedge clk);
        check("R10 no strobe after reset", stb_seen, 0);

        // Immediate-mode table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:  wr(VEC[i].addr, VEC[i].data);
                OP_CHK: wait_chk($sformatf("R%0d row %0d", VEC[i].req, i), int'(VEC[i].exp));
                OP_VD:  vd_check($sformatf("R%0d row %0d", VEC[i].req, i), int'(VEC[i].exp));
                default: ;
            endcase
        end

        // R11: exact VD latency; position 0 (4), length 2, entry 1 = 7
        @(negedge clk);
        vd_in = 1'b0;
        s0 = stb_seen;
        @(negedge clk);
        @(negedge clk);
        check("R11 index before third edge", int'(field_idx), 4);
        check("R11 strobe before third edge", int'(field_stb), 0);
        @(negedge clk);
        check("R11 index at third edge", int'(field_idx), 7);
        check("R9 strobe at load", int'(field_stb), 1);
        @(negedge clk);
        check("R9 strobe one cycle", int'(field_stb), 0);
        check("R9 single strobe", stb_seen - s0, 1);
        repeat (3) @(negedge clk);
        vd_in = 1'b1;
        repeat (5) @(negedge clk);

        // R8: VD-synchronous staging; position 1 (7)
        @(negedge clk);
        vd_sync_mode = 1'b1;
        wr(8'h2A, 25'd3);
        wr(8'h2B, {5'd0,5'd0,5'd13,5'd11,5'd10});
        wr(8'h2C, 25'd0);
        wait_chk("R8 staged write not active", 7);
        vd_check("R8 first fall uses old set", 4);
        vd_check("R8 second fall commits and restarts", 10);
        vd_check("R8 new entry 1", 11);
        vd_check("R8 new entry 2", 13);
        vd_check("R5 wrap with committed length 3", 10);

        // R12: a later write re-arms the wait
        wr(8'h2B, {5'd0,5'd0,5'd13,5'd11,5'd20});
        vd_check("R12 first fall after first write", 11);
        wr(8'h2C, 25'd0);
        vd_check("R12 second fall not a commit after re-arm", 13);
        vd_check("R12 commit on second fall after last write", 20);

        // R8 / R6: staged length only, no restart at commit
        wr(8'h2A, 25'd1);
        vd_check("R8 step before commit", 11);
        vd_check("R6 commit without restart steps with old length", 13);
        vd_check("R1 length 1 wraps to entry 0", 20);
        vd_check("R1 length 1 holds entry 0", 20);

        finish_up();
    end

endmodule